// File: doc/BRIEF.md
# Audio Codec Capture/Playback Status Byte

This block builds the read-only test and status byte of a stereo audio codec. Once per sample period, marked by a one-cycle sample strobe, it grades the left and right capture samples into four level bands around full scale. It also decides whether the playback path ran dry and whether the capture path lost a sample. Between strobes the DAC word and those flags hold their values. The data-request pin activity and the calibration indication follow their inputs every clock. The calibration indication stays asserted for a fixed number of sample periods after mode-change enable is dropped.

Playback and capture accounting run in two modes. In single-buffer mode the host writes one playback word and reads one capture word per sample. In FIFO mode the block sees the full and empty flags of external FIFOs. The block also produces the word sent to the DAC and holds the captured words, clipped to 16 bits, for the host to read. A summary bit tells a polling host that an overrun or underrun occurred.

Top module: `codec_status_unit`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the status byte, the summary bit, the DAC word and both capture words are all zero.
- R2: The status byte fields are, from bit 7 down to bit 0: capture overrun, playback underrun, calibration active, data request, right band (bits 3:2), left band (bits 1:0). The summary bit equals bit 7 OR bit 6.
- R3: At each strobe, the absolute value of each signed 18-bit capture sample sets that channel's band. The band is 00 below 29205, 01 from 29205 to 32767, 10 from 32768 to 36766, and 11 above 36766. The new band is visible from the clock after the strobe edge.
- R4: The data-request bit is the OR of the playback and capture request inputs, delayed one clock.
- R5: The calibration bit is the calibration-busy input delayed one clock, ORed with a hold window. The window starts on the clock edge that sees mode-change enable fall and ends after 128 further strobes. A new fall restarts the window at its full length.
- R6: In single-buffer mode (fifo_mode=0) a strobe with no host playback write since the previous strobe sets the underrun bit and sends 16'h0000 to the DAC. A write in that period, including one in the strobe cycle itself, clears the bit and sends the written word.
- R7: In single-buffer mode a strobe that arrives while the previous capture word is still unread, with no host read in that cycle, sets the overrun bit and discards the new sample, so the held words are unchanged. Otherwise the overrun bit clears and the new samples are stored.
- R8: In FIFO mode (fifo_mode=1) a strobe with the playback FIFO empty sets the underrun bit. The DAC then gets zero if zero_sel=1, or keeps its last word if zero_sel=0. With the FIFO not empty the bit clears and the DAC gets the FIFO head word.
- R9: In FIFO mode the overrun bit at each strobe equals the capture FIFO full flag. Every sample is stored in the capture words.
- R10: The underrun bit, the overrun bit, both bands and the DAC word change only at strobe edges.
- R11: Stored capture words are the samples saturated to the signed 16-bit range, so values above 32767 become 16'h7FFF and values below -32768 become 16'h8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | One-cycle pulse per sample period |
| fifo_mode | input | 1 | 0 single-buffer, 1 FIFO operation |
| cap_left | input | 18 | Signed pre-clip left capture sample |
| cap_right | input | 18 | Signed pre-clip right capture sample |
| pb_req | input | 1 | Playback data-request pin level |
| cap_req | input | 1 | Capture data-request pin level |
| cal_busy | input | 1 | Calibration running |
| mce | input | 1 | Mode-change enable |
| host_pb_wr | input | 1 | Host wrote a playback word this cycle |
| pb_wr_data | input | 16 | Host playback word |
| host_cap_rd | input | 1 | Host read the capture word this cycle |
| pb_fifo_empty | input | 1 | Playback FIFO empty flag |
| pb_fifo_data | input | 16 | Playback FIFO head word |
| cap_fifo_full | input | 1 | Capture FIFO full flag |
| zero_sel | input | 1 | FIFO underrun DAC value: 1 zero, 0 hold last |
| status_byte | output | 8 | Test and status byte |
| sour | output | 1 | Overrun or underrun summary |
| dac_out | output | 16 | Word presented to the DAC |
| cap_buf_left | output | 16 | Held left capture word |
| cap_buf_right | output | 16 | Held right capture word |

## Verification
The flags are recomputed only at strobes. A wrong stored value therefore persists on the status byte and on dac_out until the next strobe, and the bench samples one clock after each strobe edge. A stale unread-capture or pending-write flag first shows as a wrong overrun or underrun bit, or as a moved capture word, at the following strobe. A wrong hold counter shows only at the end of the calibration window, so the bench counts strobes up to the 127th and 128th and checks a restarted window.

// File: rtl/codec_status_pkg.sv
// Shared types for the codec status byte logic.
// Assumes: the status byte layout below is decoded by the host register path.
package codec_status_pkg;

    typedef logic [1:0] band_t;

    localparam band_t BAND_LOW   = 2'b00;
    localparam band_t BAND_NEAR  = 2'b01;
    localparam band_t BAND_OVER  = 2'b10;
    localparam band_t BAND_CLIP  = 2'b11;

    typedef struct packed {
        logic  cap_ovr;
        logic  pb_und;
        logic  cal_act;
        logic  req_act;
        band_t band_r;
        band_t band_l;
    } status_t;

endpackage

// File: rtl/csr_level_grader.sv
// Grades one capture channel into four level bands at each sample strobe.
// Assumes: sample is two's complement of CAP_W bits; thresholds are ascending.
module csr_level_grader
    import codec_status_pkg::*;
#(
    parameter int CAP_W = 18,
    parameter int TH_LO = 29205,
    parameter int TH_FS = 32768,
    parameter int TH_HI = 36766
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_stb,
    input  logic [CAP_W-1:0] sample,
    output band_t            band
);

    localparam logic [CAP_W-1:0] LIM_LO = CAP_W'(TH_LO);
    localparam logic [CAP_W-1:0] LIM_FS = CAP_W'(TH_FS);
    localparam logic [CAP_W-1:0] LIM_HI = CAP_W'(TH_HI);

    logic [CAP_W-1:0] mag;
    band_t            band_next;

    // Absolute value of the sample; the most negative code maps to its own magnitude.
    always_comb begin
        mag = sample[CAP_W-1] ? (~sample + 1'b1) : sample;
    end

    // Map the magnitude to a band code.
    always_comb begin
        if (mag < LIM_LO)       band_next = BAND_LOW;
        else if (mag < LIM_FS)  band_next = BAND_NEAR;
        else if (mag <= LIM_HI) band_next = BAND_OVER;
        else                    band_next = BAND_CLIP;
    end

    // Register the band once per sample period.
    always_ff @(posedge clk) begin
        if (!rst_n)       band <= BAND_LOW;
        else if (smp_stb) band <= band_next;
    end

    p_band_clip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && mag > LIM_HI) |=> (band == BAND_CLIP));

    p_band_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> $stable(band));

endmodule

// File: rtl/csr_cal_hold.sv
// Calibration-active indication with a hold window after mode-change exit.
// Assumes: mce is synchronous to clk; HOLD_SMP is at least 1.
module csr_cal_hold #(
    parameter int HOLD_SMP = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_stb,
    input  logic cal_busy,
    input  logic mce,
    output logic cal_act
);

    localparam int CNT_W = $clog2(HOLD_SMP + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(HOLD_SMP);

    logic             mce_q;
    logic             mce_fall;
    logic             cal_q;
    logic [CNT_W-1:0] hold_cnt;

    // Remember mode-change enable and the calibration input from the last clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mce_q <= 1'b0;
            cal_q <= 1'b0;
        end else begin
            mce_q <= mce;
            cal_q <= cal_busy;
        end
    end

    assign mce_fall = mce_q && !mce;

    // Load the window on a fall, otherwise count strobes down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                         hold_cnt <= '0;
        else if (mce_fall)                  hold_cnt <= CNT_FULL;
        else if (smp_stb && hold_cnt != 0)  hold_cnt <= hold_cnt - 1'b1;
    end

    assign cal_act = cal_q || (hold_cnt != '0);

    p_hold_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mce_fall |=> (hold_cnt == CNT_FULL));

    p_hold_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mce_fall && !smp_stb) |=> $stable(hold_cnt));

endmodule

// File: rtl/csr_xfer_track.sv
// Playback underrun and capture overrun tracking in single-buffer and FIFO modes.
// Also drives the DAC word and holds the saturated capture words.
// Assumes: host_pb_wr / host_cap_rd are one-cycle pulses; FIFO flags are current.
module csr_xfer_track #(
    parameter int CAP_W = 18,
    parameter int DAC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_stb,
    input  logic             fifo_mode,
    input  logic             zero_sel,
    input  logic             host_pb_wr,
    input  logic [DAC_W-1:0] pb_wr_data,
    input  logic             pb_fifo_empty,
    input  logic [DAC_W-1:0] pb_fifo_data,
    input  logic             host_cap_rd,
    input  logic             cap_fifo_full,
    input  logic [CAP_W-1:0] cap_l,
    input  logic [CAP_W-1:0] cap_r,
    output logic             pb_und,
    output logic             cap_ovr,
    output logic [DAC_W-1:0] dac_out,
    output logic [DAC_W-1:0] cap_buf_l,
    output logic [DAC_W-1:0] cap_buf_r
);

    localparam logic [DAC_W-1:0] MIDSCALE = '0;
    localparam logic signed [CAP_W-1:0] SAT_HI = CAP_W'((2 ** (DAC_W - 1)) - 1);
    localparam logic signed [CAP_W-1:0] SAT_LO = CAP_W'(-(2 ** (DAC_W - 1)));

    logic             pb_got;
    logic [DAC_W-1:0] pb_buf;
    logic             cap_full;
    logic [DAC_W-1:0] clip_l;
    logic [DAC_W-1:0] clip_r;

    // Saturate a wide signed sample into the DAC_W signed range.
    function automatic logic [DAC_W-1:0] sat_word(input logic [CAP_W-1:0] raw);
        logic signed [CAP_W-1:0] s;
        s = $signed(raw);
        if (s > SAT_HI)      return SAT_HI[DAC_W-1:0];
        else if (s < SAT_LO) return SAT_LO[DAC_W-1:0];
        else                 return raw[DAC_W-1:0];
    endfunction

    assign clip_l = sat_word(cap_l);
    assign clip_r = sat_word(cap_r);

    // Single-buffer playback holding register, emptied at every strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pb_got <= 1'b0;
            pb_buf <= '0;
        end else if (smp_stb) begin
            pb_got <= 1'b0;
        end else if (host_pb_wr) begin
            pb_got <= 1'b1;
            pb_buf <= pb_wr_data;
        end
    end

    // Playback decision and DAC word, once per sample period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pb_und  <= 1'b0;
            dac_out <= '0;
        end else if (smp_stb) begin
            if (fifo_mode) begin
                if (pb_fifo_empty) begin
                    pb_und <= 1'b1;
                    if (zero_sel) dac_out <= '0;
                end else begin
                    pb_und  <= 1'b0;
                    dac_out <= pb_fifo_data;
                end
            end else if (pb_got || host_pb_wr) begin
                pb_und  <= 1'b0;
                dac_out <= host_pb_wr ? pb_wr_data : pb_buf;
            end else begin
                pb_und  <= 1'b1;
                dac_out <= MIDSCALE;
            end
        end
    end

    // Capture acceptance, overrun decision and unread tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_ovr   <= 1'b0;
            cap_full  <= 1'b0;
            cap_buf_l <= '0;
            cap_buf_r <= '0;
        end else if (smp_stb) begin
            if (fifo_mode) begin
                cap_ovr   <= cap_fifo_full;
                cap_full  <= 1'b0;
                cap_buf_l <= clip_l;
                cap_buf_r <= clip_r;
            end else if (cap_full && !host_cap_rd) begin
                cap_ovr <= 1'b1;
            end else begin
                cap_ovr   <= 1'b0;
                cap_full  <= 1'b1;
                cap_buf_l <= clip_l;
                cap_buf_r <= clip_r;
            end
        end else if (host_cap_rd) begin
            cap_full <= 1'b0;
        end
    end

    p_midscale_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && !fifo_mode && !pb_got && !host_pb_wr) |=> (pb_und && dac_out == MIDSCALE));

    p_drop_new_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && !fifo_mode && cap_full && !host_cap_rd)
        |=> (cap_ovr && $stable(cap_buf_l) && $stable(cap_buf_r)));

    p_hold_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && fifo_mode && pb_fifo_empty && !zero_sel) |=> (pb_und && $stable(dac_out)));

    p_fifo_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && fifo_mode && cap_fifo_full) |=> cap_ovr);

    p_flags_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> ($stable(pb_und) && $stable(cap_ovr) && $stable(dac_out)));

endmodule

// File: rtl/codec_status_unit.sv
// Top of the codec status byte logic: level grading, request and calibration
// indication, transfer error flags and the summary bit.
// Assumes: all inputs synchronous to clk; smp_stb is a one-cycle pulse.
module codec_status_unit
    import codec_status_pkg::*;
#(
    parameter int CAP_W    = 18,
    parameter int DAC_W    = 16,
    parameter int HOLD_SMP = 128,
    parameter int TH_LO    = 29205,
    parameter int TH_FS    = 32768,
    parameter int TH_HI    = 36766
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_stb,
    input  logic             fifo_mode,
    input  logic [CAP_W-1:0] cap_left,
    input  logic [CAP_W-1:0] cap_right,
    input  logic             pb_req,
    input  logic             cap_req,
    input  logic             cal_busy,
    input  logic             mce,
    input  logic             host_pb_wr,
    input  logic [DAC_W-1:0] pb_wr_data,
    input  logic             host_cap_rd,
    input  logic             pb_fifo_empty,
    input  logic [DAC_W-1:0] pb_fifo_data,
    input  logic             cap_fifo_full,
    input  logic             zero_sel,
    output logic [7:0]       status_byte,
    output logic             sour,
    output logic [DAC_W-1:0] dac_out,
    output logic [DAC_W-1:0] cap_buf_left,
    output logic [DAC_W-1:0] cap_buf_right
);

    localparam int N_CH = 2;

    logic [CAP_W-1:0] cap_ch  [N_CH];
    band_t            band_ch [N_CH];
    logic             req_q;
    logic             cal_act;
    logic             pb_und;
    logic             cap_ovr;
    status_t          stat;

    assign cap_ch[0] = cap_left;
    assign cap_ch[1] = cap_right;

    // One level grader per capture channel.
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_grade
        csr_level_grader #(
            .CAP_W (CAP_W),
            .TH_LO (TH_LO),
            .TH_FS (TH_FS),
            .TH_HI (TH_HI)
        ) u_grade (
            .clk     (clk),
            .rst_n   (rst_n),
            .smp_stb (smp_stb),
            .sample  (cap_ch[ch]),
            .band    (band_ch[ch])
        );
    end

    // Register the combined request pin state every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= pb_req || cap_req;
    end

    csr_cal_hold #(
        .HOLD_SMP (HOLD_SMP)
    ) u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_stb  (smp_stb),
        .cal_busy (cal_busy),
        .mce      (mce),
        .cal_act  (cal_act)
    );

    csr_xfer_track #(
        .CAP_W (CAP_W),
        .DAC_W (DAC_W)
    ) u_xfer (
        .clk           (clk),
        .rst_n         (rst_n),
        .smp_stb       (smp_stb),
        .fifo_mode     (fifo_mode),
        .zero_sel      (zero_sel),
        .host_pb_wr    (host_pb_wr),
        .pb_wr_data    (pb_wr_data),
        .pb_fifo_empty (pb_fifo_empty),
        .pb_fifo_data  (pb_fifo_data),
        .host_cap_rd   (host_cap_rd),
        .cap_fifo_full (cap_fifo_full),
        .cap_l         (cap_left),
        .cap_r         (cap_right),
        .pb_und        (pb_und),
        .cap_ovr       (cap_ovr),
        .dac_out       (dac_out),
        .cap_buf_l     (cap_buf_left),
        .cap_buf_r     (cap_buf_right)
    );

    // Pack the status fields in their decoded bit order.
    always_comb begin
        stat.cap_ovr = cap_ovr;
        stat.pb_und  = pb_und;
        stat.cal_act = cal_act;
        stat.req_act = req_q;
        stat.band_r  = band_ch[1];
        stat.band_l  = band_ch[0];
    end

    assign status_byte = stat;
    assign sour        = cap_ovr || pb_und;

    p_req_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_req || cap_req) |=> status_byte[4]);

    p_sour_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> $stable(sour));

endmodule

// File: tb/codec_status_unit_tb.sv
module codec_status_unit_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_stb = 1'b0;
    logic        fifo_mode = 1'b0;
    logic [17:0] cap_left = '0;
    logic [17:0] cap_right = '0;
    logic        pb_req = 1'b0;
    logic        cap_req = 1'b0;
    logic        cal_busy = 1'b0;
    logic        mce = 1'b0;
    logic        host_pb_wr = 1'b0;
    logic [15:0] pb_wr_data = '0;
    logic        host_cap_rd = 1'b0;
    logic        pb_fifo_empty = 1'b1;
    logic [15:0] pb_fifo_data = '0;
    logic        cap_fifo_full = 1'b0;
    logic        zero_sel = 1'b0;
    logic [7:0]  status_byte;
    logic        sour;
    logic [15:0] dac_out;
    logic [15:0] cap_buf_left;
    logic [15:0] cap_buf_right;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    codec_status_unit u_dut (
        .clk (clk), .rst_n (rst_n), .smp_stb (smp_stb), .fifo_mode (fifo_mode),
        .cap_left (cap_left), .cap_right (cap_right), .pb_req (pb_req),
        .cap_req (cap_req), .cal_busy (cal_busy), .mce (mce),
        .host_pb_wr (host_pb_wr), .pb_wr_data (pb_wr_data),
        .host_cap_rd (host_cap_rd), .pb_fifo_empty (pb_fifo_empty),
        .pb_fifo_data (pb_fifo_data), .cap_fifo_full (cap_fifo_full),
        .zero_sel (zero_sel), .status_byte (status_byte), .sour (sour),
        .dac_out (dac_out), .cap_buf_left (cap_buf_left), .cap_buf_right (cap_buf_right)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // One strobe; returns at the falling edge after the strobe edge.
    task automatic strobe();
        smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
    endtask

    task automatic host_read();
        host_cap_rd = 1'b1;
        @(negedge clk);
        host_cap_rd = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 status", {24'b0, status_byte}, 32'h0);
        check("R1 sour", {31'b0, sour}, 32'h0);
        check("R1 dac", {16'b0, dac_out}, 32'h0);
        check("R1 capbuf", {cap_buf_left, cap_buf_right}, 32'h0);
    endtask

    task automatic t_band(input int l, input int r, input logic [1:0] el, input logic [1:0] er);
        cap_left  = 18'(l);
        cap_right = 18'(r);
        strobe();
        check("R3 left band", {30'b0, status_byte[1:0]}, {30'b0, el});
        check("R3 right band", {30'b0, status_byte[3:2]}, {30'b0, er});
    endtask

    task automatic t_bands();
        t_band(1000, 29204, 2'b00, 2'b00);
        t_band(29205, -32767, 2'b01, 2'b01);
        t_band(32768, 36766, 2'b10, 2'b10);
        t_band(36767, -131072, 2'b11, 2'b11);
        cap_left = 18'(10); cap_right = 18'(10);
        repeat (3) @(negedge clk);
        check("R10 band held", {28'b0, status_byte[3:0]}, 32'hF);
    endtask

    task automatic t_request();
        pb_req = 1'b1;
        @(negedge clk);
        check("R4 pb req", {31'b0, status_byte[4]}, 32'h1);
        pb_req = 1'b0; cap_req = 1'b1;
        @(negedge clk);
        check("R4 cap req", {31'b0, status_byte[4]}, 32'h1);
        cap_req = 1'b0;
        @(negedge clk);
        check("R4 idle", {31'b0, status_byte[4]}, 32'h0);
    endtask

    task automatic t_cal();
        cal_busy = 1'b1;
        @(negedge clk);
        check("R5 cal busy", {31'b0, status_byte[5]}, 32'h1);
        cal_busy = 1'b0;
        @(negedge clk);
        check("R5 cal idle", {31'b0, status_byte[5]}, 32'h0);
        mce = 1'b1;
        @(negedge clk);
        mce = 1'b0;
        @(negedge clk);
        check("R5 window start", {31'b0, status_byte[5]}, 32'h1);
        for (int i = 0; i < 50; i++) strobe();
        mce = 1'b1;
        @(negedge clk);
        mce = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 127; i++) strobe();
        check("R5 restart 127", {31'b0, status_byte[5]}, 32'h1);
        strobe();
        check("R5 window end", {31'b0, status_byte[5]}, 32'h0);
    endtask

    task automatic t_single_pb();
        fifo_mode = 1'b0;
        host_pb_wr = 1'b1; pb_wr_data = 16'h1234;
        @(negedge clk);
        host_pb_wr = 1'b0;
        repeat (2) @(negedge clk);
        strobe();
        check("R6 written word", {16'b0, dac_out}, 32'h1234);
        check("R6 no underrun", {31'b0, status_byte[6]}, 32'h0);
        strobe();
        check("R6 underrun", {31'b0, status_byte[6]}, 32'h1);
        check("R6 midscale", {16'b0, dac_out}, 32'h0);
        check("R2 sour", {31'b0, sour}, {31'b0, status_byte[7] | status_byte[6]});
        repeat (3) @(negedge clk);
        check("R10 underrun held", {31'b0, status_byte[6]}, 32'h1);
        host_pb_wr = 1'b1; pb_wr_data = 16'h0BEE;
        strobe();
        host_pb_wr = 1'b0;
        check("R6 same-cycle write", {16'b0, dac_out}, 32'h0BEE);
        check("R6 same-cycle clear", {31'b0, status_byte[6]}, 32'h0);
    endtask

    task automatic t_single_cap();
        fifo_mode = 1'b0;
        host_read();
        cap_left = 18'(1000); cap_right = 18'(-5);
        strobe();
        check("R7 accept", {cap_buf_left, cap_buf_right}, 32'h03E8FFFB);
        check("R7 no overrun", {31'b0, status_byte[7]}, 32'h0);
        cap_left = 18'(2000); cap_right = 18'(7);
        strobe();
        check("R7 overrun", {31'b0, status_byte[7]}, 32'h1);
        check("R7 new dropped", {cap_buf_left, cap_buf_right}, 32'h03E8FFFB);
        check("R2 sour overrun", {31'b0, sour}, 32'h1);
        host_read();
        cap_left = 18'(3000);
        strobe();
        check("R7 after read", {16'b0, cap_buf_left}, 32'h0BB8);
        check("R7 overrun clear", {31'b0, status_byte[7]}, 32'h0);
        host_read();
        cap_left = 18'(40000); cap_right = 18'(-40000);
        strobe();
        check("R11 saturate", {cap_buf_left, cap_buf_right}, 32'h7FFF8000);
    endtask

    task automatic t_fifo();
        fifo_mode = 1'b1;
        pb_fifo_empty = 1'b0; pb_fifo_data = 16'h0ABC; cap_fifo_full = 1'b0;
        strobe();
        check("R8 fifo word", {16'b0, dac_out}, 32'h0ABC);
        check("R8 no underrun", {31'b0, status_byte[6]}, 32'h0);
        pb_fifo_empty = 1'b1; zero_sel = 1'b0;
        strobe();
        check("R8 hold last", {16'b0, dac_out}, 32'h0ABC);
        check("R8 underrun", {31'b0, status_byte[6]}, 32'h1);
        zero_sel = 1'b1;
        strobe();
        check("R8 zero", {16'b0, dac_out}, 32'h0);
        cap_fifo_full = 1'b1; cap_left = 18'(111);
        strobe();
        check("R9 overrun", {31'b0, status_byte[7]}, 32'h1);
        check("R9 stored", {16'b0, cap_buf_left}, 32'h006F);
        cap_fifo_full = 1'b0; cap_left = 18'(222);
        strobe();
        check("R9 clear", {31'b0, status_byte[7]}, 32'h0);
        check("R9 stored again", {16'b0, cap_buf_left}, 32'h00DE);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_bands();
        t_request();
        t_cal();
        t_single_pb();
        t_single_cap();
        t_fifo();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule